// File: doc/BRIEF.md
# Fail-First Vector Length Truncation Unit

This block sits beside a vector issue loop and watches the result of each element as it completes. When an element fails its fail-first test, the block cuts the active vector length down to a contiguous run of passing elements that starts at element 0. It then raises a loop-stop signal so that the issue logic issues no further elements.

The block has two modes. In condition mode, one bit of each element's 4-bit condition field is tested for an expected value. A failure at element i sets the length to i, or to i+1 when the inclusive flag is set. In load/store mode, a per-element exception flag is watched instead. An exception on element 0 is handed on as an ordinary exception and leaves the length unchanged. An exception on any later element is swallowed and cuts the length to that element's index. The length can reach zero, and later vector operations then do nothing.

A loop is opened with a start pulse that loads the initial length. The unit does not generate conditions and does not access memory.

Top module: `ffvl_trunc_unit`

## Requirements
- R1: In the cycle after reset is applied, `vl_out` is 0, `loop_stop` is 1 and `exc_pass` is 0.
- R2: A `start` pulse loads `vl_init` into `vl_out` and clears `exc_pass` in the next cycle. `loop_stop` is 0 in that cycle, or 1 if `vl_init` is 0.
- R3: `cond_sel[1:0]` selects the tested bit of `cr_field` (0 = less-than at bit 0, 1 = greater-than at bit 1, 2 = equal at bit 2, 3 = summary-overflow at bit 3). When `cond_sel[2]` is 0 an element passes if that bit is 1. When `cond_sel[2]` is 1 (ge, le, ne, ns) it passes if the bit is 0.
- R4: In condition mode (`mode_ldst`=0), a failing strobe at element i sets `vl_out` to i + `vli` and asserts `loop_stop` in the next cycle.
- R5: With `vli`=0, a failure at element 0 sets `vl_out` to 0.
- R6: If no element fails, `vl_out` stays equal to the loaded length. `loop_stop` stays low until the cycle after the strobe for element `vl_out`-1, and rises then.
- R7: In load/store mode (`mode_ldst`=1), an exception on element 0 gives a one-cycle `exc_pass` pulse in the next cycle, leaves `vl_out` unchanged and asserts `loop_stop`.
- R8: In load/store mode, an exception on element i ≥ 1 sets `vl_out` to i, asserts `loop_stop`, and keeps `exc_pass` low.
- R9: Load/store mode ignores `cr_field`, and condition mode ignores `exc_flag`.
- R10: While `loop_stop` is 1, result strobes are ignored until the next `start`. A `start` in the same cycle as a strobe takes priority.
- R11: Cycles with `res_valid` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a new loop and loads `vl_init` |
| vl_init | input | VLW | Initial vector length |
| mode_ldst | input | 1 | 1 = load/store exception mode, 0 = condition mode |
| cond_sel | input | 3 | Condition selector: bit index in [1:0], invert in [2] |
| vli | input | 1 | Inclusive flag: keep the failing element |
| res_valid | input | 1 | Element result strobe |
| elem_idx | input | VLW | Index of the element being reported |
| cr_field | input | 4 | Element's condition field |
| exc_flag | input | 1 | Element raised an exception |
| vl_out | output | VLW | Current (possibly truncated) vector length |
| loop_stop | output | 1 | Loop has ended; no more elements are taken |
| exc_pass | output | 1 | Element-0 exception handed on as a normal exception |

## Verification
The bench sweeps all eight selectors against all sixteen condition patterns. A swapped bit or a missing inversion then shows up as a wrong length after a single element. It also goes after the boundaries:
- a failure at element 0 with the inclusive flag clear, where a design with an off-by-one would leave a length of 1 instead of 0;
- a failure at the last element with the inclusive flag set, which must leave the length unchanged;
- a load/store exception on element 0 against one on a later element, where a mix-up would either truncate to zero or swallow a real exception.

It also sends strobes after the stop and together with a start, and fails the field that the current mode should ignore. A design that failed on any of these would either cut the length again or lose a new loop's length.

// File: rtl/ffvl_pkg.sv
package ffvl_pkg;

    // Condition selector: low two bits pick the field bit, top bit inverts.
    typedef enum logic [2:0] {
        CS_LT = 3'd0,
        CS_GT = 3'd1,
        CS_EQ = 3'd2,
        CS_SO = 3'd3,
        CS_GE = 3'd4,
        CS_LE = 3'd5,
        CS_NE = 3'd6,
        CS_NS = 3'd7
    } cond_sel_e;

    // Outcome of one element strobe.
    typedef enum logic [1:0] {
        V_GO   = 2'd0,   // element passed, more to come
        V_DONE = 2'd1,   // element passed and was the last one
        V_CUT  = 2'd2,   // truncate length and stop
        V_TRAP = 2'd3    // hand on the exception, keep length, stop
    } verdict_e;

    typedef struct packed {
        logic [3:0] cr;
        logic       exc;
    } elem_status_t;

    function automatic logic cond_pass(input logic [3:0] cr, input cond_sel_e sel);
        logic [2:0] s;
        logic       b;
        s = sel;
        b = cr[s[1:0]];
        return s[2] ? ~b : b;
    endfunction

endpackage

// File: rtl/ffvl_cond_eval.sv
module ffvl_cond_eval
    import ffvl_pkg::*;
(
    input  logic [3:0] cr_field,
    input  cond_sel_e  sel,
    output logic       passed
);
    always_comb begin
        passed = cond_pass(cr_field, sel);
    end
endmodule

// File: rtl/ffvl_judge.sv
module ffvl_judge
    import ffvl_pkg::*;
#(
    parameter int VLW = 7
) (
    input  logic         mode_ldst,
    input  logic         vli,
    input  logic         cond_ok,
    input  elem_status_t status,
    input  logic [VLW-1:0] idx,
    input  logic [VLW-1:0] vl_cur,
    output verdict_e     verdict,
    output logic [VLW-1:0] tgt_vl
);
    localparam int XW = VLW + 1;

    logic is_last;
    logic is_first;

    always_comb begin
        is_last  = ((XW)'(idx) + (XW)'(1)) == (XW)'(vl_cur);
        is_first = (idx == '0);
        verdict  = V_GO;
        tgt_vl   = vl_cur;
        if (mode_ldst) begin
            if (status.exc) begin
                if (is_first) begin
                    verdict = V_TRAP;
                end else begin
                    verdict = V_CUT;
                    tgt_vl  = idx;
                end
            end else if (is_last) begin
                verdict = V_DONE;
            end
        end else begin
            if (!cond_ok) begin
                verdict = V_CUT;
                tgt_vl  = idx + {{(VLW-1){1'b0}}, vli};
            end else if (is_last) begin
                verdict = V_DONE;
            end
        end
    end
endmodule

// File: rtl/ffvl_state.sv
module ffvl_state
    import ffvl_pkg::*;
#(
    parameter int VLW = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [VLW-1:0] vl_init,
    input  logic           res_valid,
    input  verdict_e       verdict,
    input  logic [VLW-1:0] tgt_vl,
    output logic [VLW-1:0] vl_q,
    output logic           stop_q,
    output logic           exc_q
);
    logic take;
    assign take = res_valid && !stop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vl_q   <= '0;
            stop_q <= 1'b1;
            exc_q  <= 1'b0;
        end else if (start) begin
            vl_q   <= vl_init;
            stop_q <= (vl_init == '0);
            exc_q  <= 1'b0;
        end else begin
            exc_q <= 1'b0;
            if (take) begin
                unique case (verdict)
                    V_GO:   ;
                    V_DONE: stop_q <= 1'b1;
                    V_CUT: begin
                        vl_q   <= tgt_vl;
                        stop_q <= 1'b1;
                    end
                    V_TRAP: begin
                        stop_q <= 1'b1;
                        exc_q  <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6 / R4: within a loop the length never grows.
    assert_vl_no_grow_R4: assert property (@(posedge clk) disable iff (rst)
        !start |=> (vl_q <= $past(vl_q)));

    // R10: once stopped, stays stopped until a new start.
    assert_stop_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (stop_q && !start) |=> stop_q);

    // R10: once stopped, the length is frozen until a new start.
    assert_stopped_vl_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (stop_q && !start) |=> $stable(vl_q));

    // R7: handed-on exception is a single-cycle pulse with the loop stopped.
    assert_exc_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        exc_q |-> stop_q);
    assert_exc_single_R7: assert property (@(posedge clk) disable iff (rst)
        exc_q |=> !exc_q);

    // R11: no strobe and no start leaves every output unchanged.
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!start && !res_valid) |=> ($stable(vl_q) && $stable(stop_q) && !exc_q));

    // R2: start loads the initial length.
    assert_start_load_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (vl_q == $past(vl_init)));
endmodule

// File: rtl/ffvl_trunc_unit.sv
module ffvl_trunc_unit
    import ffvl_pkg::*;
#(
    parameter int MAXVL = 64,
    parameter int VLW   = $clog2(MAXVL + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [VLW-1:0] vl_init,
    input  logic           mode_ldst,
    input  logic [2:0]     cond_sel,
    input  logic           vli,
    input  logic           res_valid,
    input  logic [VLW-1:0] elem_idx,
    input  logic [3:0]     cr_field,
    input  logic           exc_flag,
    output logic [VLW-1:0] vl_out,
    output logic           loop_stop,
    output logic           exc_pass
);
    elem_status_t   status;
    logic           cond_ok;
    verdict_e       verdict;
    logic [VLW-1:0] tgt_vl;
    logic [VLW-1:0] vl_q;
    logic           stop_q;
    logic           exc_q;

    assign status.cr  = cr_field;
    assign status.exc = exc_flag;

    ffvl_cond_eval u_cond (
        .cr_field (status.cr),
        .sel      (cond_sel_e'(cond_sel)),
        .passed   (cond_ok)
    );

    ffvl_judge #(.VLW(VLW)) u_judge (
        .mode_ldst (mode_ldst),
        .vli       (vli),
        .cond_ok   (cond_ok),
        .status    (status),
        .idx       (elem_idx),
        .vl_cur    (vl_q),
        .verdict   (verdict),
        .tgt_vl    (tgt_vl)
    );

    ffvl_state #(.VLW(VLW)) u_state (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .vl_init   (vl_init),
        .res_valid (res_valid),
        .verdict   (verdict),
        .tgt_vl    (tgt_vl),
        .vl_q      (vl_q),
        .stop_q    (stop_q),
        .exc_q     (exc_q)
    );

    assign vl_out    = vl_q;
    assign loop_stop = stop_q;
    assign exc_pass  = exc_q;

    // R8: an exception beyond element 0 is never handed on.
    assert_late_exc_swallowed_R8: assert property (@(posedge clk) disable iff (rst)
        (!start && res_valid && !loop_stop && mode_ldst && exc_flag && elem_idx != '0)
        |=> (!exc_pass && loop_stop && vl_out == $past(elem_idx)));

    // R9: condition mode never hands on an exception.
    assert_cond_no_exc_R9: assert property (@(posedge clk) disable iff (rst)
        (!start && !mode_ldst) |=> !exc_pass);
endmodule

// File: tb/tb_ffvl_trunc_unit.sv
`timescale 1ns/1ps
module tb_ffvl_trunc_unit;
    localparam int MAXVL = 64;
    localparam int VLW   = $clog2(MAXVL + 1);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           s_start = 1'b0;
    logic [VLW-1:0] s_vlinit = '0;
    logic           s_mode = 1'b0;
    logic [2:0]     s_sel = 3'd0;
    logic           s_vli = 1'b0;
    logic           s_rv = 1'b0;
    logic [VLW-1:0] s_idx = '0;
    logic [3:0]     s_cr = 4'd0;
    logic           s_exc = 1'b0;
    logic [VLW-1:0] vl_out;
    logic           loop_stop;
    logic           exc_pass;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    bit    cmp_on = 0;
    string cur_req = "R1";

    int m_vl = 0;
    int m_stop = 1;
    int m_exc = 0;

    always #4 clk = ~clk;

    ffvl_trunc_unit #(.MAXVL(MAXVL)) dut (
        .clk(clk), .rst(rst), .start(s_start), .vl_init(s_vlinit),
        .mode_ldst(s_mode), .cond_sel(s_sel), .vli(s_vli),
        .res_valid(s_rv), .elem_idx(s_idx), .cr_field(s_cr), .exc_flag(s_exc),
        .vl_out(vl_out), .loop_stop(loop_stop), .exc_pass(exc_pass)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, updated on each rising edge.
    always @(posedge clk) begin
        int  b;
        bit  p;
        if (rst) begin
            m_vl = 0; m_stop = 1; m_exc = 0;
        end else if (s_start) begin
            m_vl = s_vlinit; m_stop = (s_vlinit == 0); m_exc = 0;
        end else begin
            m_exc = 0;
            if (s_rv && m_stop == 0) begin
                if (s_mode) begin
                    if (s_exc) begin
                        m_stop = 1;
                        if (s_idx == 0) m_exc = 1;
                        else m_vl = s_idx;
                    end else if (int'(s_idx) == m_vl - 1) m_stop = 1;
                end else begin
                    b = s_sel % 4;
                    p = (s_sel >= 4) ? !s_cr[b] : s_cr[b];
                    if (!p) begin
                        m_vl = s_idx + s_vli; m_stop = 1;
                    end else if (int'(s_idx) == m_vl - 1) m_stop = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(int'(vl_out) == m_vl, {cur_req, " vl_out"}, vl_out, m_vl);
            chk(int'(loop_stop) == m_stop, {cur_req, " loop_stop"}, loop_stop, m_stop);
            chk(int'(exc_pass) == m_exc, {cur_req, " exc_pass"}, exc_pass, m_exc);
        end
    end

    task automatic cyc(input bit st, input bit rv, input int idx, input bit [3:0] cr, input bit ex);
        s_start = st; s_rv = rv; s_idx = VLW'(idx); s_cr = cr; s_exc = ex;
        @(negedge clk);
    endtask

    task automatic open_loop(input int vl, input bit mode, input int sel, input bit vli);
        s_vlinit = VLW'(vl); s_mode = mode; s_sel = 3'(sel); s_vli = vli;
        cyc(1, 0, 0, 4'd0, 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        chk(vl_out == 0 && loop_stop == 1 && exc_pass == 0, "R1 reset", {vl_out, loop_stop, exc_pass}, 1);
        cmp_on = 1;

        // R10: strobes after reset but before any start are ignored
        cur_req = "R10";
        cyc(0, 1, 0, 4'd0, 0);
        chk(vl_out == 0 && loop_stop == 1, "R10 pre-start strobe", vl_out, 0);

        // R4: eq selector, vli=0, fail at 3
        cur_req = "R4";
        open_loop(8, 0, 2, 0);
        chk(vl_out == 8 && loop_stop == 0, "R2 load", vl_out, 8);
        for (int i = 0; i < 3; i++) cyc(0, 1, i, 4'b0100, 0);
        chk(loop_stop == 0, "R4 passing prefix", loop_stop, 0);
        cyc(0, 1, 3, 4'b0000, 0);
        chk(vl_out == 3 && loop_stop == 1, "R4 cut vli0", vl_out, 3);

        // R4: vli=1, fail at 5 on lt
        open_loop(8, 0, 0, 1);
        for (int i = 0; i < 5; i++) cyc(0, 1, i, 4'b0001, 0);
        cyc(0, 1, 5, 4'b1110, 0);
        chk(vl_out == 6 && loop_stop == 1, "R4 cut vli1", vl_out, 6);

        // R4: vli=1 failure at last element keeps full length
        open_loop(3, 0, 1, 1);
        cyc(0, 1, 0, 4'b0010, 0);
        cyc(0, 1, 1, 4'b0010, 0);
        cyc(0, 1, 2, 4'b0000, 0);
        chk(vl_out == 3 && loop_stop == 1, "R4 last inclusive", vl_out, 3);

        // R5: element 0 fails with vli=0
        cur_req = "R5";
        open_loop(5, 0, 3, 0);
        cyc(0, 1, 0, 4'b0111, 0);
        chk(vl_out == 0 && loop_stop == 1, "R5 zero length", vl_out, 0);

        // R6 + R11: all pass on ge, with idle gaps carrying failing fields
        cur_req = "R6";
        open_loop(4, 0, 4, 0);
        for (int i = 0; i < 4; i++) begin
            cyc(0, 1, i, 4'b0010, 0);
            if (i == 2) chk(loop_stop == 0, "R6 not yet stopped", loop_stop, 0);
            cyc(0, 0, i, 4'b1111, 0);
            chk(vl_out == 4, "R11 idle gap", vl_out, 4);
        end
        chk(vl_out == 4 && loop_stop == 1, "R6 full run", vl_out, 4);

        // R3: sweep selectors against every condition pattern
        cur_req = "R3";
        for (int sel = 0; sel < 8; sel++) begin
            for (int cr = 0; cr < 16; cr++) begin
                bit b;
                bit p;
                b = cr[sel % 4];
                p = (sel >= 4) ? !b : b;
                open_loop(2, 0, sel, 0);
                cyc(0, 1, 0, 4'(cr), 0);
                chk(int'(vl_out) == (p ? 2 : 0) && loop_stop == !p,
                    "R3 selector sweep", vl_out, p ? 2 : 0);
            end
        end

        // R7: exception on element 0 in load/store mode
        cur_req = "R7";
        open_loop(5, 1, 0, 0);
        cyc(0, 1, 0, 4'b0000, 1);
        chk(exc_pass == 1 && vl_out == 5 && loop_stop == 1, "R7 first exc", exc_pass, 1);
        cyc(0, 0, 0, 4'b0000, 0);
        chk(exc_pass == 0, "R7 pulse ends", exc_pass, 0);

        // R8: exception on element 3
        cur_req = "R8";
        open_loop(6, 1, 0, 1);
        for (int i = 0; i < 3; i++) cyc(0, 1, i, 4'b0000, 0);
        cyc(0, 1, 3, 4'b0000, 1);
        chk(vl_out == 3 && loop_stop == 1 && exc_pass == 0, "R8 late exc", vl_out, 3);

        // R9: load/store mode ignores failing condition fields
        cur_req = "R9";
        open_loop(4, 1, 2, 0);
        for (int i = 0; i < 4; i++) cyc(0, 1, i, 4'b0000, 0);
        chk(vl_out == 4 && loop_stop == 1, "R9 ldst ignores cr", vl_out, 4);
        // condition mode ignores exception flag
        open_loop(4, 0, 2, 0);
        for (int i = 0; i < 4; i++) cyc(0, 1, i, 4'b0100, 1);
        chk(vl_out == 4 && exc_pass == 0, "R9 cond ignores exc", vl_out, 4);

        // R10: strobes after stop ignored; start wins over a strobe
        cur_req = "R10";
        cyc(0, 1, 0, 4'b0000, 0);
        chk(vl_out == 4 && loop_stop == 1, "R10 after stop", vl_out, 4);
        s_vlinit = VLW'(7);
        cyc(1, 1, 0, 4'b0000, 0);
        chk(vl_out == 7 && loop_stop == 0, "R10 start priority", vl_out, 7);

        // R2: start with zero length stops at once
        cur_req = "R2";
        open_loop(0, 0, 0, 0);
        chk(vl_out == 0 && loop_stop == 1, "R2 zero init", vl_out, 0);
        open_loop(MAXVL, 0, 0, 0);
        chk(int'(vl_out) == MAXVL && loop_stop == 0, "R2 max init", vl_out, MAXVL);
        cyc(0, 1, MAXVL - 1, 4'b0000, 0);
        chk(int'(vl_out) == MAXVL - 1, "R4 fail at top index", vl_out, MAXVL - 1);

        cyc(0, 0, 0, 4'b0000, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule